// File: doc/BRIEF.md
# Two-Wire Target Register Port with Auto-Increment Pointer

This block is the bus side of a 20-byte register file. It watches the SCL and SDA lines of a two-wire (I2C) bus from a fast system clock that oversamples both lines. It finds START, repeated START and STOP conditions and checks the 7-bit device address. It then loads a word pointer, or reads and writes data bytes one after another while the pointer steps forward. SDA is driven as an open-drain line through an output enable: when `sda_oe` is high the pin is pulled low. The register storage sits outside the block. It is reached through a pointer-addressed port, with a one-cycle write strobe and a combinational read path.

While the bus has selected this target and the pointer is inside the timekeeping range (00h to 07h), the block raises `hold`. Timekeeping logic outside the block uses `hold` to freeze its updates of the user-visible time copies. A STOP, or the pointer moving to 08h or above, releases it.

The controller is one state machine. Its states are IDLE (bus free), DEVADR (address byte coming in), DEVACK (address acknowledge), PTRBYTE and PTRACK (word address and its acknowledge), RXBYTE and RXACK (written data and its acknowledge), TXBYTE and TXACK (read data out and the master's acknowledge), and SKIP (not addressed, or read ended by a NACK). The transitions are:
- A START from any state goes to DEVADR.
- A STOP from any state goes to IDLE.
- DEVADR goes to DEVACK on a match, and to SKIP otherwise.
- DEVACK goes to TXBYTE for a read and to PTRBYTE for a write.
- PTRBYTE goes to PTRACK, then to RXBYTE.
- RXBYTE and RXACK alternate.
- TXBYTE goes to TXACK. TXACK goes back to TXBYTE on an ACK, and to SKIP on a NACK.

Top module: `i2c_regport`

## Requirements
- R1: An address byte of D0h (address 1101000, write) or D1h (read) is acknowledged. Any other address byte gets no acknowledge, causes no register write, and leaves SDA released until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer. Each later byte is written to the register at the pointer with a single-cycle `reg_wr` pulse. The target acknowledges the word address and every data byte.
- R3: During writes, the pointer advances by one at the end of each data-byte acknowledge clock. It never leaves 00h..13h and wraps from 13h to 00h.
- R4: A word address of 14h or above loads the pointer with 00h.
- R5: After a repeated START with the read bit, the target returns the byte at the pointer, MSB first. The pointer advances by one, wrapping from 13h to 00h, only when the master acknowledges a byte.
- R6: When the master does not acknowledge a read byte, the target releases SDA, the pointer does not advance, and the target stays silent until the next START or STOP.
- R7: The pointer survives STOP. A read with no pointer write starts at the address the previous transfer left.
- R8: `hold` is high only while the target is selected and the pointer is below 08h. It falls after a STOP, or when the pointer reaches 08h or above.
- R9: After reset, `sda_oe`, `hold` and `reg_wr` are low and the pointer is 00h.
- R10: The target changes `sda_oe` only while the filtered SCL is low, except when it releases SDA because of a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 5 | Current pointer, used as register address |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Byte at `reg_addr`, combinational from storage |
| hold | output | 1 | Freeze request for time-copy updates |

## Verification
Four properties are checked on every cycle:
- The pointer stays in range, and every pointer change that is not a load is a step of plus one with wrap.
- Each write strobe lasts exactly one cycle.
- A STOP releases both `hold` and SDA.
- SDA changes only while SCL is low.

Other behaviour needs the bench's bus transfers to show it: acknowledgement of matching and non-matching addresses, the data returned for each start address, current-address reads after a NACK, the out-of-range word address load, and the exact point where `hold` drops. The bench sweeps a random read from every one of the 20 start addresses.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_PTRBYTE,
        ST_PTRACK,
        ST_RXBYTE,
        ST_RXACK,
        ST_TXBYTE,
        ST_TXACK,
        ST_SKIP
    } st_t;
endpackage

// File: rtl/i2cr_linefilt.sv
// Two-flop synchronizer followed by a majority-free agreement filter:
// the output only moves once FILT_LEN consecutive samples agree.
module i2cr_linefilt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic s1_q, s2_q;
    logic [FILT_LEN-1:0] win_q;
    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            win_q <= '1;
            out_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
            if (FILT_LEN > 1) begin
                win_q <= {win_q[FILT_LEN-2:0], s2_q};
            end else begin
                win_q <= s2_q;
            end
            if (&win_q) begin
                out_q <= 1'b1;
            end else if (~|win_q) begin
                out_q <= 1'b0;
            end
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/i2cr_busdet.sv
// Edge and bus-condition detection on the filtered lines.
module i2cr_busdet (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2cr_ptr.sv
// Word pointer: load with range clamp, increment with wrap.
module i2cr_ptr #(
    parameter int NUM_REGS = 20,
    parameter int AW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [7:0]    ld_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld) begin
            ptr_q <= (ld_val < 8'(NUM_REGS)) ? ld_val[AW-1:0] : '0;
        end else if (inc) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h68,
    parameter int         NUM_REGS   = 20,
    parameter int         HOLD_LIMIT = 8,
    parameter int         FILT_LEN   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [4:0] reg_addr,
    output logic       reg_wr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    output logic       hold
);
    localparam int AW = 5;

    logic [1:0] raw_lines, filt_lines;
    logic scl_f, sda_s;
    logic scl_rise, scl_fall, start_c, stop_c;

    st_t st_q, st_nx;
    logic [BYTE_W-1:0] sh_q;
    logic [2:0] cnt_q;
    logic full_q, rw_q, mack_q, sel_q;
    logic adr_hit, bus_cond;
    logic ptr_ld, ptr_inc;
    logic [AW-1:0] ptr;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cr_linefilt #(.FILT_LEN(FILT_LEN)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_s = filt_lines[0];

    i2cr_busdet det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    assign bus_cond = start_c | stop_c;
    assign adr_hit  = (sh_q[7:1] == DEV_ADDR);

    // pointer control
    assign ptr_ld  = !bus_cond && (st_q == ST_PTRBYTE) && scl_fall && full_q;
    assign ptr_inc = !bus_cond &&
                     (((st_q == ST_RXACK) && scl_fall) ||
                      ((st_q == ST_TXACK) && scl_rise && !sda_s));

    i2cr_ptr #(.NUM_REGS(NUM_REGS), .AW(AW)) ptr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ptr_ld),
        .ld_val (sh_q),
        .inc    (ptr_inc),
        .ptr    (ptr)
    );

    // next-state logic
    always_comb begin
        st_nx = st_q;
        if (stop_c) begin
            st_nx = ST_IDLE;
        end else if (start_c) begin
            st_nx = ST_DEVADR;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_SKIP: st_nx = st_q;
                ST_DEVADR:  if (scl_fall && full_q) st_nx = adr_hit ? ST_DEVACK : ST_SKIP;
                ST_DEVACK:  if (scl_fall) st_nx = rw_q ? ST_TXBYTE : ST_PTRBYTE;
                ST_PTRBYTE: if (scl_fall && full_q) st_nx = ST_PTRACK;
                ST_PTRACK:  if (scl_fall) st_nx = ST_RXBYTE;
                ST_RXBYTE:  if (scl_fall && full_q) st_nx = ST_RXACK;
                ST_RXACK:   if (scl_fall) st_nx = ST_RXBYTE;
                ST_TXBYTE:  if (scl_fall && cnt_q == 3'd7) st_nx = ST_TXACK;
                ST_TXACK:   if (scl_fall) st_nx = mack_q ? ST_TXBYTE : ST_SKIP;
                default:    st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (stop_c) begin
                sel_q  <= 1'b0;
                full_q <= 1'b0;
                cnt_q  <= '0;
            end else if (start_c) begin
                full_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                unique case (st_q)
                    ST_DEVADR, ST_PTRBYTE, ST_RXBYTE: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 3'd1;
                            if (cnt_q == 3'd7) full_q <= 1'b1;
                        end else if (scl_fall && full_q) begin
                            full_q <= 1'b0;
                            cnt_q  <= '0;
                            if (st_q == ST_DEVADR) begin
                                sel_q <= adr_hit;
                                rw_q  <= sh_q[0];
                            end
                        end
                    end
                    ST_DEVACK: begin
                        if (scl_fall && rw_q) begin
                            sh_q  <= reg_rdata;
                            cnt_q <= '0;
                        end
                    end
                    ST_TXBYTE: begin
                        if (scl_fall) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                            cnt_q <= cnt_q + 3'd1;
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall && mack_q) begin
                            sh_q  <= reg_rdata;
                            cnt_q <= '0;
                        end
                    end
                    default: begin
                        cnt_q <= cnt_q;
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (st_q)
            ST_DEVACK, ST_PTRACK, ST_RXACK: sda_oe = 1'b1;
            ST_TXBYTE:                      sda_oe = ~sh_q[BYTE_W-1];
            default:                        sda_oe = 1'b0;
        endcase
        reg_wr    = !bus_cond && (st_q == ST_RXBYTE) && scl_fall && full_q;
        reg_wdata = sh_q;
        reg_addr  = ptr;
        hold      = sel_q && (ptr < AW'(HOLD_LIMIT));
    end
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk #(
    parameter int NUM_REGS = 20,
    parameter int AW       = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_f,
    input logic          start_c,
    input logic          stop_c,
    input logic          ptr_ld,
    input logic          sda_oe,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic          hold
);
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr < AW'(NUM_REGS)); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg_addr) && !$past(ptr_ld)) |->
        (reg_addr == (($past(reg_addr) == AW'(NUM_REGS - 1)) ? '0 : $past(reg_addr) + AW'(1)))); // R5

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R2

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!hold && !sda_oe)); // R8

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe)); // R10
endmodule

bind i2c_regport i2cr_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .ptr_ld   (ptr_ld),
    .sda_oe   (sda_oe),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .hold     (hold)
);

// File: tb/i2c_regport_tb_top.sv
module i2c_regport_tb_top;
    localparam int N = 20;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_wr, hold;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regport dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hold      (hold)
    );

    // external storage model
    logic [7:0] mem [N];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= 8'h00;
        end else if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    logic [7:0] exp_mem [N];
    int nchk = 0;
    int nbad = 0;
    int eptr = 0;

    task automatic ck(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
        qw();
    endtask

    task automatic wb(input logic [7:0] b, output logic ak);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl_m = 1'b1; qw(); qw();
            scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        ak = ~sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic rb(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            scl_m = 1'b1; qw();
            d[i] = sda_line; qw();
            scl_m = 1'b0;
        end
        qw();
        sda_m = ~give_ack; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int i, input int k);
        return 8'((i * 37 + k * 11 + 5) & 255);
    endfunction

    // pointer write, no STOP
    task automatic set_ptr(input logic [7:0] a);
        logic ak;
        bus_start();
        wb(8'hD0, ak); ck("R1 write address ack", ak, 1);
        wb(a, ak);     ck("R2 word address ack", ak, 1);
        eptr = (a < N) ? a : 0;
    endtask

    // read n bytes after a (repeated) START, last one NACKed
    task automatic rd_seq(input int n, input string tag);
        logic ak;
        logic [7:0] d;
        bus_start();
        wb(8'hD1, ak); ck("R1 read address ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            rb(k < n - 1, d);
            ck(tag, d, exp_mem[eptr]);
            if (k < n - 1) eptr = (eptr + 1) % N;
        end
        qw();
        ck("R6 SDA released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        logic ak;
        for (int i = 0; i < N; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R9 reset state
        ck("R9 sda_oe at reset", sda_oe, 0);
        ck("R9 hold at reset", hold, 0);
        ck("R9 reg_wr at reset", reg_wr, 0);
        ck("R9 pointer at reset", reg_addr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // full write sweep from 00h
        set_ptr(8'h00);
        qw();
        ck("R8 hold with pointer in clock range", hold, 1);
        for (int k = 0; k < N; k++) begin
            wb(pat(k, 0), ak);
            ck("R2 data ack", ak, 1);
            exp_mem[eptr] = pat(k, 0);
            eptr = (eptr + 1) % N;
            if (k == 7) begin
                qw();
                ck("R8 hold released at pointer 08h", hold, 0);
            end
        end
        bus_stop();
        ck("R3 pointer wrapped after 20 writes", reg_addr, 0);
        ck("R8 hold after STOP", hold, 0);
        for (int i = 0; i < N; i++) ck("R2 storage content", mem[i], exp_mem[i]);

        // random read of all 20 bytes
        set_ptr(8'h00);
        rd_seq(N, "R5 sequential read");

        // current-address reads (R7) and NACK keeps pointer (R6)
        rd_seq(1, "R7 current read at last pointer");
        rd_seq(1, "R6 pointer unchanged after NACK");
        rd_seq(2, "R5 read wraps 13h to 00h");

        // wrapping write from 12h
        set_ptr(8'h12);
        for (int k = 0; k < 3; k++) begin
            wb(pat(k, 3), ak);
            ck("R3 wrap write ack", ak, 1);
            exp_mem[eptr] = pat(k, 3);
            eptr = (eptr + 1) % N;
        end
        bus_stop();
        ck("R3 pointer after wrap write", reg_addr, 1);
        set_ptr(8'h12);
        rd_seq(3, "R3 wrap write readback");

        // out-of-range word address
        set_ptr(8'h1F);
        bus_stop();
        ck("R4 pointer after word 1Fh", reg_addr, 0);
        rd_seq(1, "R4 read after out-of-range word");

        // non-matching addresses
        for (int j = 0; j < 4; j++) begin
            logic [7:0] bad;
            bad = (j == 0) ? 8'hD2 : (j == 1) ? 8'h50 : (j == 2) ? 8'h50 ^ 8'hFF : 8'h68;
            bus_start();
            wb(bad, ak);         ck("R1 mismatch not acked", ak, 0);
            wb(8'h03, ak);       ck("R1 ignored byte not acked", ak, 0);
            wb(8'hEE, ak);       ck("R1 ignored data not acked", ak, 0);
            ck("R1 no hold when not addressed", hold, 0);
            bus_stop();
            ck("R1 storage untouched", mem[3], exp_mem[3]);
        end

        // sweep random reads over every start address
        for (int s = 0; s < N; s++) begin
            set_ptr(8'(s));
            qw();
            ck("R8 hold follows start address", hold, (s < 8) ? 1 : 0);
            rd_seq(2, "R5 random read sweep");
            ck("R8 hold low after STOP", hold, 0);
        end

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule